// File: doc/BRIEF.md
# Selectively Flushed Micro Translation Cache

This block is a small, fully associative translation cache built from flops. It sits between a requester (instruction fetch or load/store) and a slower, 2-way set-associative main TLB. A lookup presents a virtual page number, an 8-bit address-space identifier, the privilege mode and the access kind. In the same cycle the block reports a hit, the physical frame number and whether the access is permitted. The same module serves as the data-side cache with `ENTRIES = 8` and as the instruction-side cache with `ENTRIES = 4`.

On a miss the block raises a refill request toward the main TLB and holds it until the main TLB either acknowledges with an entry or reports that no translation exists. An acknowledged entry is installed. A "no translation" answer produces a one-cycle fault pulse toward the requester.

Entries are never dropped when the main TLB replaces its own copy. Because of this, the higher associativity here hides conflict thrashing in the main TLB. The only way to remove entries in bulk is the invalidate strobe, which the main TLB raises on a committed write or on an explicit flush command.

Top module: `utlb_cache`

## Requirements
- R1: A lookup (`lk_valid` high) whose page number and ASID match a valid entry raises `lk_hit` and drives that entry's frame number on `lk_pfn` combinationally, in the same cycle.
- R2: An entry installed with `rf_global` high matches its page number under any ASID. A non-global entry matches only when the ASID is equal.
- R3: The permission field is `rf_perm[5:0]`, with bit 5 kernel-read, bit 4 kernel-write, bit 3 kernel-exec, bit 2 user-read, bit 1 user-write and bit 0 user-exec. `lk_user` = 0 selects the kernel bits and 1 selects the user bits. `lk_acc` = 0 is read, 1 is write, 2 is execute, and 3 is always denied. `lk_allow` is the selected bit, gated by a hit.
- R4: A lookup miss while no refill is outstanding raises `rf_req` on the next cycle, carrying the missed page and ASID on `rf_vpn`/`rf_asid`. These values are held unchanged until `rf_ack` or `rf_miss`, including while other lookups miss.
- R5: `rf_ack` during a request installs `rf_pfn`, `rf_perm` and `rf_global` for the requested page. `rf_req` drops the next cycle, and from then on a lookup of that page hits.
- R6: `rf_miss` during a request (without `rf_ack`) raises `lk_fault` for exactly one cycle, in the following cycle. It drops `rf_req` and installs nothing.
- R7: Installs fill the lowest-numbered invalid entry first. When all entries are valid, the victim is chosen round-robin, starting at entry 0 after reset or invalidate.
- R8: `inval` clears every entry from the next cycle and restarts the round-robin position at entry 0. Nothing else removes a valid entry.
- R9: When `inval` and `rf_ack` arrive in the same cycle, the invalidate wins. The returned entry is discarded, and the request still completes.
- R10: `rf_ack` or `rf_miss` with no outstanding request has no effect on the contents.
- R11: After reset the cache is empty, and `rf_req` and `lk_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the requester |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_pfn | output | PFN_W | Frame number of the matching entry |
| lk_allow | output | 1 | Access permitted by the matching entry |
| lk_fault | output | 1 | One-cycle pulse: main TLB had no translation |
| rf_req | output | 1 | Refill request to the main TLB |
| rf_vpn | output | VPN_W | Page number being refilled |
| rf_asid | output | ASID_W | ASID being refilled |
| rf_ack | input | 1 | Main TLB returns an entry |
| rf_miss | input | 1 | Main TLB has no entry for the request |
| rf_pfn | input | PFN_W | Returned frame number |
| rf_perm | input | 6 | Returned permission bits (see R3) |
| rf_global | input | 1 | Returned entry ignores ASID |
| inval | input | 1 | Flush every entry |

## Verification
The assertions assume that `rf_ack` and `rf_miss` are never high together and that the main TLB answers only the outstanding request. The bench answers every request with exactly one of the two and drives strays only in the dedicated R10 case. The one-hot lowest-index match also assumes the same page is never present twice under overlapping ASID rules. The stimulus guarantees this by giving every installed page a distinct number.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    // bit 5 down to bit 0: kernel r/w/x then user r/w/x
    typedef struct packed {
        logic kr;
        logic kw;
        logic kx;
        logic ur;
        logic uw;
        logic ux;
    } perm_t;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rwx_t;

    function automatic logic perm_ok(perm_t p, logic user, acc_e a);
        rwx_t t;
        t = user ? rwx_t'{p.ur, p.uw, p.ux} : rwx_t'{p.kr, p.kw, p.kx};
        case (a)
            ACC_RD:  return t.r;
            ACC_WR:  return t.w;
            ACC_EX:  return t.x;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/utlb_match.sv
module utlb_match #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int IW     = 3
) (
    input  logic [N-1:0]      vld,
    input  logic [VPN_W-1:0]  e_vpn  [N],
    input  logic [ASID_W-1:0] e_asid [N],
    input  logic [N-1:0]      e_glb,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    output logic              hit,
    output logic [IW-1:0]     idx
);
    logic [N-1:0] hv;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hv[g] = vld[g] && (e_vpn[g] == q_vpn) &&
                       (e_glb[g] || (e_asid[g] == q_asid));
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hv[i]) idx = IW'(i);
        end
        hit = |hv;
    end
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  vld,
    input  logic          install,
    input  logic          flush,
    output logic [IW-1:0] victim
);
    logic [IW-1:0] rr_q;
    logic [IW-1:0] free_idx;
    logic          full;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IW'(i);
        end
        full   = &vld;
        victim = full ? rr_q : free_idx;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rr_q <= '0;
        end else if (install && full) begin
            rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // R7
    fill_free_chk: assert property (@(posedge clk) disable iff (rst)
        (install && !full) |=> ($countones(vld) == $countones($past(vld)) + 1));

    // R7
    rotate_chk: assert property (@(posedge clk) disable iff (rst)
        (install && full && !flush) |=> (rr_q != $past(rr_q)));
endmodule

// File: rtl/utlb_perm.sv
module utlb_perm
    import utlb_pkg::*;
(
    input  perm_t perm,
    input  logic  user,
    input  acc_e  acc,
    output logic  ok
);
    assign ok = perm_ok(perm, user, acc);
endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_user,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_allow,
    output logic              lk_fault,
    output logic              rf_req,
    output logic [VPN_W-1:0]  rf_vpn,
    output logic [ASID_W-1:0] rf_asid,
    input  logic              rf_ack,
    input  logic              rf_miss,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [5:0]        rf_perm,
    input  logic              rf_global,
    input  logic              inval
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] e_glb;
    logic [VPN_W-1:0]   e_vpn  [ENTRIES];
    logic [ASID_W-1:0]  e_asid [ENTRIES];
    logic [PFN_W-1:0]   e_pfn  [ENTRIES];
    perm_t              e_perm [ENTRIES];

    logic               pend_q;
    logic               fault_q;
    logic [VPN_W-1:0]   cap_vpn;
    logic [ASID_W-1:0]  cap_asid;

    logic               m_hit;
    logic [IW-1:0]      m_idx;
    logic [IW-1:0]      victim;
    logic               perm_ok_w;
    logic               install;
    logic               done;

    utlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IW(IW)) u_match (
        .vld   (vld),
        .e_vpn (e_vpn),
        .e_asid(e_asid),
        .e_glb (e_glb),
        .q_vpn (lk_vpn),
        .q_asid(lk_asid),
        .hit   (m_hit),
        .idx   (m_idx)
    );

    utlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
        .clk    (clk),
        .rst    (rst),
        .vld    (vld),
        .install(install),
        .flush  (inval),
        .victim (victim)
    );

    utlb_perm u_perm (
        .perm(e_perm[m_idx]),
        .user(lk_user),
        .acc (acc_e'(lk_acc)),
        .ok  (perm_ok_w)
    );

    assign install  = pend_q && rf_ack && !inval;
    assign done     = pend_q && (rf_ack || rf_miss);
    assign lk_hit   = lk_valid && m_hit;
    assign lk_pfn   = lk_hit ? e_pfn[m_idx] : '0;
    assign lk_allow = lk_hit && perm_ok_w;
    assign lk_fault = fault_q;
    assign rf_req   = pend_q;
    assign rf_vpn   = cap_vpn;
    assign rf_asid  = cap_asid;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld      <= '0;
            pend_q   <= 1'b0;
            fault_q  <= 1'b0;
            cap_vpn  <= '0;
            cap_asid <= '0;
        end else begin
            fault_q <= pend_q && rf_miss && !rf_ack;
            if (inval) begin
                vld <= '0;
            end else if (install) begin
                vld[victim] <= 1'b1;
            end
            if (done) begin
                pend_q <= 1'b0;
            end else if (!pend_q && lk_valid && !m_hit) begin
                pend_q   <= 1'b1;
                cap_vpn  <= lk_vpn;
                cap_asid <= lk_asid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            e_vpn[victim]  <= cap_vpn;
            e_asid[victim] <= cap_asid;
            e_pfn[victim]  <= rf_pfn;
            e_perm[victim] <= perm_t'(rf_perm);
            e_glb[victim]  <= rf_global;
        end
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_req && !rf_ack && !rf_miss) |=>
        (rf_req && $stable(rf_vpn) && $stable(rf_asid)));

    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_req && rf_ack) |=> !rf_req);

    // R6
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_req && rf_miss && !rf_ack) |=> (lk_fault && !rf_req));

    // R8
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        inval |=> (vld == '0));

    // R10
    stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!rf_req && !inval) |=> (vld == $past(vld)));
endmodule

// File: tb/utlb_cache_test.sv
module utlb_cache_test;
    localparam int N  = 8;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic          lk_user = 1'b0;
    logic [1:0]    lk_acc = 2'd0;
    logic          lk_hit;
    logic [PW-1:0] lk_pfn;
    logic          lk_allow;
    logic          lk_fault;
    logic          rf_req;
    logic [VW-1:0] rf_vpn;
    logic [AW-1:0] rf_asid;
    logic          rf_ack = 1'b0;
    logic          rf_miss = 1'b0;
    logic [PW-1:0] rf_pfn = '0;
    logic [5:0]    rf_perm = '0;
    logic          rf_global = 1'b0;
    logic          inval = 1'b0;

    always #5 clk = ~clk;

    utlb_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) uut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_user(lk_user), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_allow(lk_allow), .lk_fault(lk_fault),
        .rf_req(rf_req), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
        .rf_ack(rf_ack), .rf_miss(rf_miss), .rf_pfn(rf_pfn),
        .rf_perm(rf_perm), .rf_global(rf_global), .inval(inval)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit            m_v    [N];
    logic [VW-1:0] m_vpn  [N];
    logic [AW-1:0] m_asid [N];
    bit            m_g    [N];
    logic [PW-1:0] m_pfn  [N];
    logic [5:0]    m_perm [N];
    int            m_rr = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_find(logic [VW-1:0] vpn, logic [AW-1:0] asid);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid)) return i;
        return -1;
    endfunction

    function automatic void m_install(logic [VW-1:0] vpn, logic [AW-1:0] asid,
                                      logic [PW-1:0] pfn, logic [5:0] perm, bit g);
        int v = -1;
        for (int i = 0; i < N; i++) if (!m_v[i] && v < 0) v = i;
        if (v < 0) begin
            v = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_v[v] = 1; m_vpn[v] = vpn; m_asid[v] = asid;
        m_pfn[v] = pfn; m_perm[v] = perm; m_g[v] = g;
    endfunction

    function automatic void m_flush();
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_rr = 0;
    endfunction

    function automatic bit exp_allow(logic [5:0] p, bit user, int acc);
        if (acc == 3) return 0;
        return user ? p[2 - acc] : p[5 - acc];
    endfunction

    task automatic look(input logic [VW-1:0] vpn, input logic [AW-1:0] asid,
                        input bit user, input int acc);
        @(negedge clk);
        rf_ack = 0; rf_miss = 0; inval = 0;
        lk_valid = 1; lk_vpn = vpn; lk_asid = asid; lk_user = user; lk_acc = 2'(acc);
        #1;
    endtask

    task automatic probe(input logic [VW-1:0] vpn, input logic [AW-1:0] asid,
                         input bit user, input int acc, input string req);
        int idx;
        look(vpn, asid, user, acc);
        idx = m_find(vpn, asid);
        chk(lk_hit == (idx >= 0), req, lk_hit, idx >= 0);
        if (idx >= 0) begin
            chk(lk_pfn == m_pfn[idx], req, lk_pfn, m_pfn[idx]);
            chk(lk_allow == exp_allow(m_perm[idx], user, acc), req, lk_allow,
                exp_allow(m_perm[idx], user, acc));
        end else begin
            @(negedge clk);
            lk_valid = 0; rf_miss = 1;
            #1 chk(rf_req == 1, "R4", rf_req, 1);
            @(negedge clk);
            rf_miss = 0;
            #1 chk(lk_fault == 1 && rf_req == 0, "R6", {lk_fault, rf_req}, 2'b10);
            @(negedge clk);
            #1 chk(lk_fault == 0, "R6", lk_fault, 0);
        end
    endtask

    task automatic fill(input logic [VW-1:0] vpn, input logic [AW-1:0] asid,
                        input logic [PW-1:0] pfn, input logic [5:0] perm, input bit g);
        look(vpn, asid, 0, 0);
        chk(lk_hit == 0, "R5", lk_hit, 0);
        @(negedge clk);
        lk_valid = 0;
        #1 chk(rf_req && rf_vpn == vpn && rf_asid == asid, "R4", rf_vpn, vpn);
        rf_ack = 1; rf_pfn = pfn; rf_perm = perm; rf_global = g;
        @(negedge clk);
        rf_ack = 0;
        #1 chk(rf_req == 0, "R5", rf_req, 0);
        m_install(vpn, asid, pfn, perm, g);
    endtask

    initial begin
        #(2_000_000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_flush();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R11: reset state
        chk(rf_req == 0 && lk_fault == 0, "R11", {rf_req, lk_fault}, 0);
        probe(20'h00010, 8'd1, 0, 0, "R11");

        // R1: fill every entry, then hit each one
        for (int i = 0; i < N; i++)
            fill(VW'(i * 7 + 3), AW'(i + 1), PW'(20'h100 + i * 20'h111), 6'h3F, 0);
        for (int i = 0; i < N; i++)
            probe(VW'(i * 7 + 3), AW'(i + 1), 0, 0, "R1");

        // R2: ASID mismatch misses, global entry matches any ASID
        probe(VW'(10), 8'd60, 0, 0, "R2");
        fill(20'h00500, 8'd9, 20'hABCDE, 6'h24, 1);
        probe(20'h00500, 8'd200, 1, 0, "R2");
        probe(20'h00500, 8'd9, 0, 0, "R2");

        // R7: round-robin replacement over a full array
        for (int i = 0; i < 5; i++)
            fill(VW'(20'h700 + i), AW'(3), PW'(20'h7000 + i), 6'h3F, 0);
        for (int i = 0; i < N; i++)
            probe(VW'(i * 7 + 3), AW'(i + 1), 0, 0, "R7");
        for (int i = 0; i < 5; i++)
            probe(VW'(20'h700 + i), AW'(3), 0, 0, "R7");
        probe(20'h00500, 8'd1, 0, 0, "R7");

        // R8: invalidate clears all and restarts the rotation
        @(negedge clk);
        lk_valid = 0; inval = 1;
        @(negedge clk);
        inval = 0;
        m_flush();
        probe(20'h00701, 8'd3, 0, 0, "R8");
        for (int i = 0; i < N + 2; i++)
            fill(VW'(20'h900 + i), AW'(4), PW'(20'h900 + i), 6'h09, 0);
        for (int i = 0; i < N + 2; i++)
            probe(VW'(20'h900 + i), AW'(4), 1, 0, "R8");

        // R3: every permission pattern under every mode and access kind
        for (int p = 0; p < 64; p++) begin
            fill(VW'(20'h2000 + p), AW'(5), PW'(p * 3 + 1), 6'(p), 0);
            for (int u = 0; u < 2; u++)
                for (int a = 0; a < 4; a++)
                    probe(VW'(20'h2000 + p), AW'(5), u[0], a, "R3");
        end

        // R9: invalidate and acknowledge in one cycle
        look(20'h03000, 8'd5, 0, 0);
        chk(lk_hit == 0, "R9", lk_hit, 0);
        @(negedge clk);
        lk_valid = 0; rf_ack = 1; inval = 1; rf_pfn = 20'h33333; rf_perm = 6'h3F; rf_global = 0;
        @(negedge clk);
        rf_ack = 0; inval = 0;
        #1 chk(rf_req == 0, "R9", rf_req, 0);
        m_flush();
        probe(20'h03000, 8'd5, 0, 0, "R9");

        // R10: stray acknowledge and stray miss with no request outstanding
        @(negedge clk);
        rf_ack = 1; rf_pfn = 20'h44444;
        @(negedge clk);
        rf_ack = 0; rf_miss = 1;
        @(negedge clk);
        rf_miss = 0;
        #1 chk(rf_req == 0 && lk_fault == 0, "R10", {rf_req, lk_fault}, 0);
        probe(20'h03000, 8'd5, 0, 0, "R10");

        // R4: request holds through further misses
        look(20'h04000, 8'd3, 0, 0);
        @(negedge clk);
        lk_vpn = 20'h04444;
        #1 chk(rf_req && rf_vpn == 20'h04000, "R4", rf_vpn, 20'h04000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1 chk(rf_req && rf_vpn == 20'h04000 && rf_asid == 8'd3, "R4", rf_vpn, 20'h04000);
        end
        lk_valid = 0; rf_ack = 1; rf_pfn = 20'h04040; rf_perm = 6'h38; rf_global = 0;
        @(negedge clk);
        rf_ack = 0;
        m_install(20'h04000, 8'd3, 20'h04040, 6'h38, 0);
        probe(20'h04000, 8'd3, 0, 1, "R5");
        probe(20'h04444, 8'd3, 0, 0, "R5");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule